// File: doc/BRIEF.md
# Prioritized Interrupt Queue Controller

This block collects interrupt events from 41 on-chip and external sources and presents one winner to the processor. Each source has a raise pulse and a clear pulse. A raise marks the source pending. It stays pending until its own clear pulse arrives. The block picks the pending source with the highest priority and outputs its index and fixed event code. It asserts an interrupt request when the processor's block bit and mask level allow it.

Fifteen external request lines and the non-maskable source have fixed priorities. Every peripheral source takes its level from a 4-bit field in one of three 16-bit priority registers, and one field can be shared by a group of sources. A fourth register, the control register, is stored and read back but changes nothing. Reading the selected code is the accept step and does not remove the source. Software or the handler must clear the source to retire it.

Top module: `intc_queue`

## Requirements
- R1: After reset the pending set is empty, `sel_valid`, `sel_idx`, `sel_code` and `irq_req` are 0, and all four registers read 0. This gives external lines 0..14 fixed priorities 15 down to 1, the non-maskable source (index 15) a fixed priority of 16, and all peripheral sources priority 0.
- R2: A raise for a source whose current priority is 0 is dropped and leaves no pending state behind.
- R3: A source is pending at most once. A repeated raise of a pending source changes nothing, and one clear removes it.
- R4: The selected source is the pending source with the highest priority, and equal priorities go to the lower index. Source indices are: external lines 0..14, non-maskable 15, debug 16, GPIO 17, DMA channels 18..21, DMA address error 22, timer underflows 23..25, timer capture 26, RTC 27..29, serial port 30..33, FIFO serial port 34..37, watchdog 38, memory refresh 39..40.
- R5: `irq_req` is 1 only when a source is selected, `cpu_block` is 0, and `cpu_mask` is strictly less than the selected source's priority.
- R6: The selected source stays selected and pending until a clear for it arrives, however long the code is observed. A clear and a raise for the same source in the same cycle leave it not pending.
- R7: Event codes: external line n gives 0x200+0x20·n, non-maskable gives 0x1C0, and indices 16..22 give 0x600+0x20·(i−16). Indices 23..33 give 0x400+0x20·(i−23), 34..37 give 0x700+0x20·(i−34), and 38..40 give 0x560+0x20·(i−38).
- R8: Register A (address 1): bits 15:12 set source 23, bits 11:8 set source 24, bits 7:4 set sources 25 and 26, and bits 3:0 set sources 27..29.
- R9: Register B (address 2): bits 15:12 set source 38, bits 11:8 set sources 39..40, and bits 7:4 set sources 30..33. Bits 3:0 are stored but set no priority.
- R10: Register C (address 3): bits 15:12 set source 17, bits 11:8 set sources 18..22, bits 7:4 set sources 34..37, and bits 3:0 set source 16.
- R11: A read of any address returns the last value written there, one cycle after the address is presented. Writes to the control register (address 0) change no selection or request.
- R12: A raise sampled at clock edge k makes the source pending at edge k. The selection outputs reflect it at edge k+1, and the request uses `cpu_block` and `cpu_mask` as sampled at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raise | input | 41 | Per-source raise pulses |
| clear | input | 41 | Per-source clear pulses |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address (0 control, 1 A, 2 B, 3 C) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data for `reg_addr` |
| cpu_block | input | 1 | Processor block bit; 1 suppresses the request |
| cpu_mask | input | 4 | Processor interrupt mask level |
| sel_valid | output | 1 | A source is selected |
| sel_idx | output | 6 | Index of the selected source |
| sel_code | output | 12 | Event code of the selected source |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
The assertions check on every cycle that a block bit silences the request, that a request never appears without a selection, and that no source becomes pending without a raise at nonzero priority. They also check that a clear always wins and that the valid flag follows the pending set. Only the bench scenarios can show which source wins: the priority-then-index order, the mapping of each register field onto its group, the event code table, the strict mask comparison and the two-edge latency all need known stimulus and expected values.

// File: rtl/intc_queue_pkg.sv
package intc_queue_pkg;
  localparam int NSRC   = 41;
  localparam int PRIO_W = 5;
  localparam int IDX_W  = $clog2(NSRC);
  localparam int CODE_W = 12;
  localparam int NEXT   = 15;   // external request lines
  localparam int I_NMI  = 15;
  localparam int I_DBG  = 16;
  localparam int I_GPIO = 17;
  localparam int I_DMA0 = 18;   // 18..22
  localparam int I_TMR0 = 23;   // 23..26
  localparam int I_RTC0 = 27;   // 27..29
  localparam int I_SER0 = 30;   // 30..33
  localparam int I_FSR0 = 34;   // 34..37
  localparam int I_WDG  = 38;
  localparam int I_REF0 = 39;   // 39..40

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_PA   = 2'd1,
    RA_PB   = 2'd2,
    RA_PC   = 2'd3
  } reg_addr_e;

  function automatic logic [CODE_W-1:0] code_of(input int i);
    int base;
    int off;
    if (i < NEXT)        begin base = 'h200; off = i;          end
    else if (i == I_NMI) begin base = 'h1C0; off = 0;          end
    else if (i < I_TMR0) begin base = 'h600; off = i - I_DBG;  end
    else if (i < I_FSR0) begin base = 'h400; off = i - I_TMR0; end
    else if (i < I_WDG)  begin base = 'h700; off = i - I_FSR0; end
    else                 begin base = 'h560; off = i - I_WDG;  end
    return CODE_W'(base + 'h20 * off);
  endfunction
endpackage

// File: rtl/intc_prio_map.sv
module intc_prio_map
  import intc_queue_pkg::*;
(
  input  logic [15:0]                        prio_a,
  input  logic [15:0]                        prio_b,
  input  logic [15:0]                        prio_c,
  output logic [NSRC-1:0][PRIO_W-1:0]        prio
);
  always_comb begin
    for (int i = 0; i < NSRC; i++) prio[i] = '0;
    for (int i = 0; i < NEXT; i++) prio[i] = PRIO_W'(NEXT - i);
    prio[I_NMI]  = PRIO_W'(16);
    prio[I_DBG]  = {1'b0, prio_c[3:0]};
    prio[I_GPIO] = {1'b0, prio_c[15:12]};
    for (int i = I_DMA0; i < I_TMR0; i++) prio[i] = {1'b0, prio_c[11:8]};
    prio[I_TMR0]     = {1'b0, prio_a[15:12]};
    prio[I_TMR0 + 1] = {1'b0, prio_a[11:8]};
    prio[I_TMR0 + 2] = {1'b0, prio_a[7:4]};
    prio[I_TMR0 + 3] = {1'b0, prio_a[7:4]};
    for (int i = I_RTC0; i < I_SER0; i++) prio[i] = {1'b0, prio_a[3:0]};
    for (int i = I_SER0; i < I_FSR0; i++) prio[i] = {1'b0, prio_b[7:4]};
    for (int i = I_FSR0; i < I_WDG; i++)  prio[i] = {1'b0, prio_c[7:4]};
    prio[I_WDG] = {1'b0, prio_b[15:12]};
    for (int i = I_REF0; i < NSRC; i++)   prio[i] = {1'b0, prio_b[11:8]};
  end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int N  = 41,
  parameter int PW = 5,
  parameter int IW = 6
) (
  input  logic [N-1:0]          pend,
  input  logic [N-1:0][PW-1:0]  prio,
  output logic                  win_valid,
  output logic [IW-1:0]         win_idx,
  output logic [PW-1:0]         win_prio
);
  localparam int LVL = $clog2(N);
  localparam int W   = 1 << LVL;

  logic          nv [1:2*W-1];
  logic [PW-1:0] np [1:2*W-1];
  logic [IW-1:0] ni [1:2*W-1];

  for (genvar k = 0; k < W; k++) begin : g_leaf
    if (k < N) begin : g_real
      assign nv[W+k] = pend[k];
      assign np[W+k] = prio[k];
    end else begin : g_pad
      assign nv[W+k] = 1'b0;
      assign np[W+k] = '0;
    end
    assign ni[W+k] = IW'(k);
  end

  // Left child always holds lower indices, so ties stay left.
  for (genvar n = 1; n < W; n++) begin : g_node
    logic take_r;
    assign take_r = nv[2*n+1] && (!nv[2*n] || (np[2*n+1] > np[2*n]));
    assign nv[n]  = nv[2*n] | nv[2*n+1];
    assign np[n]  = take_r ? np[2*n+1] : np[2*n];
    assign ni[n]  = take_r ? ni[2*n+1] : ni[2*n];
  end

  assign win_valid = nv[1];
  assign win_idx   = ni[1];
  assign win_prio  = np[1];
endmodule

// File: rtl/intc_queue.sv
module intc_queue
  import intc_queue_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   raise,
  input  logic [NSRC-1:0]   clear,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              cpu_block,
  input  logic [3:0]        cpu_mask,
  output logic              sel_valid,
  output logic [IDX_W-1:0]  sel_idx,
  output logic [CODE_W-1:0] sel_code,
  output logic              irq_req
);
  logic [15:0] ctrl_q, pa_q, pb_q, pc_q;
  logic [NSRC-1:0][PRIO_W-1:0] prio;
  logic [NSRC-1:0] prio_nz;
  logic [NSRC-1:0] pend;
  logic            win_valid;
  logic [IDX_W-1:0] win_idx;
  logic [PRIO_W-1:0] win_prio;
  logic [CODE_W-1:0] win_code;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0; pa_q <= '0; pb_q <= '0; pc_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr_e'(reg_addr))
        RA_CTRL: ctrl_q <= reg_wdata;
        RA_PA:   pa_q   <= reg_wdata;
        RA_PB:   pb_q   <= reg_wdata;
        RA_PC:   pc_q   <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr_e'(reg_addr))
        RA_CTRL: reg_rdata <= ctrl_q;
        RA_PA:   reg_rdata <= pa_q;
        RA_PB:   reg_rdata <= pb_q;
        default: reg_rdata <= pc_q;
      endcase
    end
  end

  intc_prio_map u_map (
    .prio_a (pa_q),
    .prio_b (pb_q),
    .prio_c (pc_q),
    .prio   (prio)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_nz
    assign prio_nz[i] = |prio[i];
  end

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend | (raise & prio_nz)) & ~clear;
  end

  intc_arbiter #(.N(NSRC), .PW(PRIO_W), .IW(IDX_W)) u_arb (
    .pend      (pend),
    .prio      (prio),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_prio  (win_prio)
  );

  always_comb begin
    win_code = '0;
    for (int i = 0; i < NSRC; i++)
      if (win_idx == IDX_W'(i)) win_code = code_of(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_valid <= 1'b0; sel_idx <= '0; sel_code <= '0; irq_req <= 1'b0;
    end else begin
      sel_valid <= win_valid;
      sel_idx   <= win_valid ? win_idx : '0;
      sel_code  <= win_valid ? win_code : '0;
      irq_req   <= win_valid && !cpu_block && ({1'b0, cpu_mask} < win_prio);
    end
  end
endmodule

// File: rtl/intc_queue_chk.sv
module intc_queue_chk
  import intc_queue_pkg::*;
(
  input logic                       clk,
  input logic                       rst,
  input logic [NSRC-1:0]            raise,
  input logic [NSRC-1:0]            clear,
  input logic [NSRC-1:0][PRIO_W-1:0] prio,
  input logic [NSRC-1:0]            pend,
  input logic                       cpu_block,
  input logic                       sel_valid,
  input logic [IDX_W-1:0]           sel_idx,
  input logic                       irq_req
);
  logic [NSRC-1:0] raise_ok;
  always_comb
    for (int i = 0; i < NSRC; i++) raise_ok[i] = raise[i] && (prio[i] != '0);

  AST_REQ_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> sel_valid);  // R5
  AST_BLOCK_SILENCES: assert property (@(posedge clk) disable iff (rst)
    $past(cpu_block) |-> !irq_req);  // R5
  AST_ZERO_PRIO_DROP: assert property (@(posedge clk) disable iff (rst)
    (pend & ~$past(pend) & ~$past(raise_ok)) == '0);  // R2
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    (pend & $past(clear)) == '0);  // R6
  AST_VALID_TRACKS: assert property (@(posedge clk) disable iff (rst)
    sel_valid == ($past(pend) != '0));  // R12
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> (sel_idx < IDX_W'(NSRC)));  // R4
endmodule

bind intc_queue intc_queue_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .raise     (raise),
  .clear     (clear),
  .prio      (prio),
  .pend      (pend),
  .cpu_block (cpu_block),
  .sel_valid (sel_valid),
  .sel_idx   (sel_idx),
  .irq_req   (irq_req)
);

// File: tb/tb_intc_queue.sv
`timescale 1ns/1ps
module tb_intc_queue;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [40:0] raise = '0;
  logic [40:0] clear = '0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        cpu_block = 1'b0;
  logic [3:0]  cpu_mask = '0;
  logic        sel_valid;
  logic [5:0]  sel_idx;
  logic [11:0] sel_code;
  logic        irq_req;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  intc_queue dut (.*);

  function automatic logic [40:0] bit_of(input int i);
    return 41'(1) << i;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse_raise(input logic [40:0] v);
    @(negedge clk) raise = v;
    @(negedge clk) raise = '0;
    @(negedge clk);
  endtask

  task automatic pulse_clear(input logic [40:0] v);
    @(negedge clk) clear = v;
    @(negedge clk) clear = '0;
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk) begin reg_wr = 1'b1; reg_addr = a; reg_wdata = d; end
    @(negedge clk) reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk) reg_addr = a;
    @(negedge clk) d = reg_rdata;
  endtask

  task automatic expect_sel(input string req, input int idx, input int code);
    chk({req, " valid"}, 32'(sel_valid), 32'd1);
    chk({req, " idx"},   32'(sel_idx),   32'(idx));
    chk({req, " code"},  32'(sel_code),  32'(code));
  endtask

  task automatic reset_all();
    pulse_clear('1);
    wr_reg(2'd1, 16'h0); wr_reg(2'd2, 16'h0); wr_reg(2'd3, 16'h0);
    cpu_block = 1'b0; cpu_mask = '0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 valid", 32'(sel_valid), 0);
    chk("R1 req", 32'(irq_req), 0);
    chk("R1 code", 32'(sel_code), 0);
    for (int a = 0; a < 4; a++) begin
      rd_reg(2'(a), d);
      chk("R1 reg", 32'(d), 0);
    end
    pulse_raise(bit_of(23));
    chk("R1 periph prio 0", 32'(sel_valid), 0);
  endtask

  task automatic t_latency();
    @(negedge clk) raise = bit_of(3);
    @(negedge clk) raise = '0;
    chk("R12 not yet", 32'(sel_valid), 0);
    @(negedge clk);
    expect_sel("R12 R7 irq3", 3, 'h260);
    chk("R12 req", 32'(irq_req), 1);
    reset_all();
  endtask

  task automatic t_fixed_order();
    pulse_raise(bit_of(3));
    pulse_raise(bit_of(1));
    expect_sel("R4 irq1 over irq3", 1, 'h220);
    pulse_raise(bit_of(15));
    expect_sel("R4 R7 nmi", 15, 'h1C0);
    repeat (6) @(negedge clk);
    expect_sel("R6 accept keeps", 15, 'h1C0);
    pulse_clear(bit_of(15));
    expect_sel("R6 after clear", 1, 'h220);
    pulse_clear(bit_of(1));
    expect_sel("R6 next", 3, 'h260);
    reset_all();
    chk("R6 empty", 32'(sel_valid), 0);
  endtask

  task automatic t_drop_dup();
    pulse_raise(bit_of(24));
    chk("R2 zero prio dropped", 32'(sel_valid), 0);
    wr_reg(2'd1, 16'h0800);
    @(negedge clk);
    chk("R2 no late pending", 32'(sel_valid), 0);
    pulse_raise(bit_of(24));
    expect_sel("R8 timer1", 24, 'h420);
    pulse_raise(bit_of(24));
    pulse_clear(bit_of(24));
    chk("R3 one clear empties", 32'(sel_valid), 0);
    @(negedge clk) begin raise = bit_of(0); clear = bit_of(0); end
    @(negedge clk) begin raise = '0; clear = '0; end
    @(negedge clk);
    chk("R6 clear beats raise", 32'(sel_valid), 0);
    reset_all();
  endtask

  task automatic t_reg_a();
    wr_reg(2'd1, 16'h5333);
    pulse_raise(bit_of(27) | bit_of(26));
    expect_sel("R4 tie lower idx", 26, 'h460);
    pulse_clear(bit_of(26));
    expect_sel("R8 rtc", 27, 'h480);
    pulse_raise(bit_of(23));
    expect_sel("R8 timer0", 23, 'h400);
    reset_all();
  endtask

  task automatic t_reg_b();
    logic [15:0] d;
    wr_reg(2'd2, 16'h000F);
    rd_reg(2'd2, d);
    chk("R11 B readback", 32'(d), 'h000F);
    pulse_raise(bit_of(30) | bit_of(38) | bit_of(40));
    chk("R9 low bits no prio", 32'(sel_valid), 0);
    wr_reg(2'd2, 16'h7240);
    pulse_raise(bit_of(40));
    expect_sel("R9 refresh", 40, 'h5A0);
    pulse_raise(bit_of(30));
    expect_sel("R9 sci prio4", 30, 'h4E0);
    pulse_raise(bit_of(38));
    expect_sel("R9 watchdog", 38, 'h560);
    reset_all();
  endtask

  task automatic t_reg_c();
    wr_reg(2'd3, 16'h1234);
    pulse_raise(bit_of(16) | bit_of(17) | bit_of(22) | bit_of(37));
    expect_sel("R10 debug prio4", 16, 'h600);
    pulse_clear(bit_of(16));
    expect_sel("R10 scif prio3", 37, 'h760);
    pulse_clear(bit_of(37));
    expect_sel("R10 dma err", 22, 'h6C0);
    pulse_clear(bit_of(22));
    expect_sel("R10 gpio", 17, 'h620);
    reset_all();
  endtask

  task automatic t_gating();
    logic [15:0] d;
    pulse_raise(bit_of(14));
    expect_sel("R7 irq14", 14, 'h3C0);
    chk("R5 mask0", 32'(irq_req), 1);
    @(negedge clk) cpu_mask = 4'd1;
    @(negedge clk);
    chk("R5 strict mask", 32'(irq_req), 0);
    @(negedge clk) begin cpu_mask = 4'd0; cpu_block = 1'b1; end
    @(negedge clk);
    chk("R5 block", 32'(irq_req), 0);
    @(negedge clk) cpu_block = 1'b0;
    @(negedge clk);
    chk("R5 unblock", 32'(irq_req), 1);
    wr_reg(2'd0, 16'hFFFF);
    rd_reg(2'd0, d);
    chk("R11 ctrl readback", 32'(d), 'hFFFF);
    expect_sel("R11 ctrl no effect", 14, 'h3C0);
    chk("R11 ctrl req", 32'(irq_req), 1);
    reset_all();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_latency();
    t_fixed_order();
    t_drop_dup();
    t_reg_a();
    t_reg_b();
    t_reg_c();
    t_gating();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule